// File: doc/BRIEF.md
# Sliding-Window Parallel FIR Slice Array

This block computes P consecutive outputs of a finite impulse response filter at the same time. It uses P multiply-accumulate slices fed from a group memory. Each memory word is a group of P signed samples stored under one address. A single read therefore hands one element to every slice. A start pulse supplies the tap count N, the address of the first coefficient group and the address of the "current" data group. The block then reads a coefficient group, the current data group and one older data group into group registers. On every tap it broadcasts one coefficient to all slices over a shared bus. Each slice multiplies that coefficient with its own element of a data window and adds the product to its accumulator.

After each tap the window moves one element toward the highest slice. The vacated lowest position takes the newest unused sample from a backup group register. Because of this, earlier samples are reused instead of being fetched again. Memory is touched only when the coefficient group or the backup group has been used up. The number of reads therefore does not depend on the number of slices in use. When all N taps are done, a one-cycle done pulse marks the P accumulator values as final. They stay on the output until the next accepted start.

Top module: `sw_fir_array`

## Requirements
- R1: While reset is active and after it is released with no start, `done_o` and `mem_rd_o` are 0 and every output slice reads 0.
- R2: A start pulse is accepted only when the block is idle. A start raised while a computation is running is ignored. The running result, its reads and its tap count are unchanged.
- R3: The first read after an accepted start is issued in the next cycle and targets `coef_base_i`. The second read targets `data_base_i`. When N > 1, the third read targets `data_base_i - 1`, and later backup groups come from successively lower addresses.
- R4: Let x_rel[m] be element (m mod P) of the group at address `data_base_i + floor(m/P)`. Slice j (bits j*ACCW upward) then ends with the sum over taps i = 0..N-1 of c_i * x_rel[j-i]. Samples and coefficients are signed two's complement of W bits.
- R5: Coefficient c_i is element (i mod P) of the group at address `coef_base_i + floor(i/P)`. The same c_i is applied to every slice in the same tap.
- R6: A run of N taps issues exactly ceil(N/P) coefficient reads, one current-data read and ceil((N-1)/P) backup reads. No group is read twice.
- R7: `done_o` is high for exactly one cycle per run. The outputs are final in that cycle and hold their value until the next accepted start.
- R8: Accumulators are 2*W + log2(NMAX) bits wide. With full-scale negative samples and coefficients and N = NMAX the result is exact, with no overflow or sign error.
- R9: With N = 1 each slice outputs c_0 times its own element of the current data group.
- R10: Once `done_o` has been given, no memory read is issued until a new start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| ntaps_i | input | $clog2(NMAX+1) | Tap count N, 1..NMAX |
| coef_base_i | input | AW | Address of the first coefficient group |
| data_base_i | input | AW | Address of the current data group |
| mem_rd_o | output | 1 | Group read request; data returns one cycle later |
| mem_addr_o | output | AW | Group read address |
| mem_rdata_i | input | P*W | Group read data, element e at bits e*W |
| y_o | output | P*(2*W+$clog2(NMAX)) | Slice accumulators, slice j at bits j*ACCW |
| done_o | output | 1 | One-cycle pulse when all taps are accumulated |

## Verification
The bound checker watches four things on every cycle. Done is a single-cycle pulse, and the outputs stay stable after it. The first read after an accepted start goes to the coefficient base. Memory stays silent between the end of a run and the next start. The arithmetic of every slice can only be shown by the bench's scenarios against a scalar filter model. The same holds for the exact read count per run, the order of the data and backup addresses, the ignoring of a start raised mid-run, and full-scale accumulation. The scenarios cover the tap counts 1, below P, equal to P, just above P, several groups, and NMAX.

// File: rtl/swfir_pkg.sv
package swfir_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_COEF,
    ST_RD_DATA,
    ST_RD_BACK,
    ST_SETTLE,
    ST_MAC
  } seq_state_t;

  typedef enum logic [1:0] {
    DST_NONE,
    DST_COEF,
    DST_DATA,
    DST_BACK
  } cap_dst_t;

endpackage

// File: rtl/swfir_seq.sv
module swfir_seq
  import swfir_pkg::*;
#(
  parameter int P    = 8,
  parameter int NMAX = 32,
  parameter int AW   = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [$clog2(NMAX+1)-1:0] ntaps_i,
  input  logic [AW-1:0]            coef_base_i,
  input  logic [AW-1:0]            data_base_i,
  output logic                     mem_rd_o,
  output logic [AW-1:0]            mem_addr_o,
  output cap_dst_t                 cap_dst_o,
  output logic                     mac_en_o,
  output logic                     acc_clr_o,
  output logic                     shift_en_o,
  output logic [((P>1)?$clog2(P):1)-1:0] cidx_o,
  output logic                     busy_o,
  output logic                     done_o
);

  localparam int TW = $clog2(NMAX+1);
  localparam int IW = (P > 1) ? $clog2(P) : 1;

  seq_state_t      state_q, state_n;
  cap_dst_t        pend_q, pend_n;
  logic [TW-1:0]   tap_q, tap_n, ntaps_q;
  logic [IW-1:0]   phase_q, phase_n;
  logic [AW-1:0]   cgrp_q, cgrp_n, bgrp_q, bgrp_n;
  logic [AW-1:0]   cbase_q, dbase_q;
  logic            back_need_q, back_need_n;
  logic            done_q, done_n;
  logic            ld_cfg;
  logic            last_tap;
  logic            more_shifts;

  assign last_tap    = (tap_q == ntaps_q - TW'(1));
  assign more_shifts = (({1'b0, tap_q} + (TW+1)'(2)) < {1'b0, ntaps_q});

  always_comb begin
    state_n     = state_q;
    pend_n      = DST_NONE;
    tap_n       = tap_q;
    phase_n     = phase_q;
    cgrp_n      = cgrp_q;
    bgrp_n      = bgrp_q;
    back_need_n = back_need_q;
    done_n      = 1'b0;
    ld_cfg      = 1'b0;
    mem_rd_o    = 1'b0;
    mem_addr_o  = '0;
    mac_en_o    = 1'b0;
    shift_en_o  = 1'b0;
    acc_clr_o   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          ld_cfg      = 1'b1;
          acc_clr_o   = 1'b1;
          tap_n       = '0;
          phase_n     = '0;
          cgrp_n      = '0;
          bgrp_n      = '0;
          back_need_n = 1'b0;
          state_n     = ST_RD_COEF;
        end
      end
      ST_RD_COEF: begin
        mem_rd_o   = 1'b1;
        mem_addr_o = cbase_q + cgrp_q;
        pend_n     = DST_COEF;
        if (tap_q == '0)      state_n = ST_RD_DATA;
        else if (back_need_q) state_n = ST_RD_BACK;
        else                  state_n = ST_SETTLE;
      end
      ST_RD_DATA: begin
        mem_rd_o   = 1'b1;
        mem_addr_o = dbase_q;
        pend_n     = DST_DATA;
        state_n    = (ntaps_q > TW'(1)) ? ST_RD_BACK : ST_SETTLE;
      end
      ST_RD_BACK: begin
        mem_rd_o   = 1'b1;
        mem_addr_o = dbase_q - AW'(1) - bgrp_q;
        pend_n     = DST_BACK;
        bgrp_n     = bgrp_q + AW'(1);
        state_n    = ST_SETTLE;
      end
      ST_SETTLE: begin
        state_n = ST_MAC;
      end
      ST_MAC: begin
        mac_en_o = 1'b1;
        if (last_tap) begin
          done_n  = 1'b1;
          state_n = ST_IDLE;
        end else begin
          shift_en_o = 1'b1;
          tap_n      = tap_q + TW'(1);
          if (phase_q == IW'(P-1)) begin
            phase_n     = '0;
            cgrp_n      = cgrp_q + AW'(1);
            back_need_n = more_shifts;
            state_n     = ST_RD_COEF;
          end else begin
            phase_n = phase_q + IW'(1);
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      pend_q      <= DST_NONE;
      tap_q       <= '0;
      phase_q     <= '0;
      cgrp_q      <= '0;
      bgrp_q      <= '0;
      back_need_q <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      state_q     <= state_n;
      pend_q      <= pend_n;
      tap_q       <= tap_n;
      phase_q     <= phase_n;
      cgrp_q      <= cgrp_n;
      bgrp_q      <= bgrp_n;
      back_need_q <= back_need_n;
      done_q      <= done_n;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ntaps_q <= '0;
      cbase_q <= '0;
      dbase_q <= '0;
    end else if (ld_cfg) begin
      ntaps_q <= ntaps_i;
      cbase_q <= coef_base_i;
      dbase_q <= data_base_i;
    end
  end

  assign cap_dst_o = pend_q;
  assign cidx_o    = phase_q;
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;

endmodule

// File: rtl/swfir_window.sv
module swfir_window
  import swfir_pkg::*;
#(
  parameter int P = 8,
  parameter int W = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  cap_dst_t                      cap_dst_i,
  input  logic [P*W-1:0]                rdata_i,
  input  logic                          shift_en_i,
  input  logic [((P>1)?$clog2(P):1)-1:0] cidx_i,
  output logic [W-1:0]                  coef_bc_o,
  output logic [P*W-1:0]                win_o
);

  logic [W-1:0] coef_q [P];
  logic [W-1:0] coef_n [P];
  logic [W-1:0] win_q  [P];
  logic [W-1:0] win_n  [P];
  logic [W-1:0] back_q [P];
  logic [W-1:0] back_n [P];

  always_comb begin
    for (int e = 0; e < P; e++) begin
      coef_n[e] = coef_q[e];
      win_n[e]  = win_q[e];
      back_n[e] = back_q[e];
    end
    if (cap_dst_i == DST_COEF) begin
      for (int e = 0; e < P; e++) coef_n[e] = rdata_i[e*W +: W];
    end
    if (cap_dst_i == DST_DATA) begin
      for (int e = 0; e < P; e++) win_n[e] = rdata_i[e*W +: W];
    end else if (shift_en_i) begin
      win_n[0] = back_q[P-1];
      for (int e = 1; e < P; e++) win_n[e] = win_q[e-1];
    end
    if (cap_dst_i == DST_BACK) begin
      for (int e = 0; e < P; e++) back_n[e] = rdata_i[e*W +: W];
    end else if (shift_en_i) begin
      back_n[0] = '0;
      for (int e = 1; e < P; e++) back_n[e] = back_q[e-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < P; e++) begin
        coef_q[e] <= '0;
        win_q[e]  <= '0;
        back_q[e] <= '0;
      end
    end else begin
      for (int e = 0; e < P; e++) begin
        coef_q[e] <= coef_n[e];
        win_q[e]  <= win_n[e];
        back_q[e] <= back_n[e];
      end
    end
  end

  assign coef_bc_o = coef_q[cidx_i];

  generate
    for (genvar g = 0; g < P; g++) begin : g_pack
      assign win_o[g*W +: W] = win_q[g];
    end
  endgenerate

endmodule

// File: rtl/swfir_slice.sv
module swfir_slice #(
  parameter int W    = 16,
  parameter int ACCW = 37
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            en_i,
  input  logic [W-1:0]    coef_i,
  input  logic [W-1:0]    x_i,
  output logic [ACCW-1:0] acc_o
);

  logic signed [2*W-1:0]  prod;
  logic        [ACCW-1:0] acc_q, acc_n;

  assign prod = $signed(coef_i) * $signed(x_i);

  always_comb begin
    acc_n = acc_q;
    if (clr_i)     acc_n = '0;
    else if (en_i) acc_n = acc_q + {{(ACCW-2*W){prod[2*W-1]}}, prod};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            acc_q <= '0;
    else if (clr_i || en_i) acc_q <= acc_n;
  end

  assign acc_o = acc_q;

endmodule

// File: rtl/sw_fir_array.sv
module sw_fir_array
  import swfir_pkg::*;
#(
  parameter int P    = 8,
  parameter int W    = 16,
  parameter int NMAX = 32,
  parameter int AW   = 8,
  localparam int TW   = $clog2(NMAX+1),
  localparam int ACCW = 2*W + $clog2(NMAX),
  localparam int IW   = (P > 1) ? $clog2(P) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [TW-1:0]     ntaps_i,
  input  logic [AW-1:0]     coef_base_i,
  input  logic [AW-1:0]     data_base_i,
  output logic              mem_rd_o,
  output logic [AW-1:0]     mem_addr_o,
  input  logic [P*W-1:0]    mem_rdata_i,
  output logic [P*ACCW-1:0] y_o,
  output logic              done_o
);

  cap_dst_t       cap_dst;
  logic           mac_en, acc_clr, shift_en, busy;
  logic [IW-1:0]  cidx;
  logic [W-1:0]   coef_bc;
  logic [P*W-1:0] win;

  swfir_seq #(.P(P), .NMAX(NMAX), .AW(AW)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .ntaps_i     (ntaps_i),
    .coef_base_i (coef_base_i),
    .data_base_i (data_base_i),
    .mem_rd_o    (mem_rd_o),
    .mem_addr_o  (mem_addr_o),
    .cap_dst_o   (cap_dst),
    .mac_en_o    (mac_en),
    .acc_clr_o   (acc_clr),
    .shift_en_o  (shift_en),
    .cidx_o      (cidx),
    .busy_o      (busy),
    .done_o      (done_o)
  );

  swfir_window #(.P(P), .W(W)) u_win (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_dst_i  (cap_dst),
    .rdata_i    (mem_rdata_i),
    .shift_en_i (shift_en),
    .cidx_i     (cidx),
    .coef_bc_o  (coef_bc),
    .win_o      (win)
  );

  generate
    for (genvar j = 0; j < P; j++) begin : g_slice
      swfir_slice #(.W(W), .ACCW(ACCW)) u_slice (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (acc_clr),
        .en_i   (mac_en),
        .coef_i (coef_bc),
        .x_i    (win[j*W +: W]),
        .acc_o  (y_o[j*ACCW +: ACCW])
      );
    end
  endgenerate

endmodule

// File: rtl/swfir_chk.sv
module swfir_chk #(
  parameter int AW = 8,
  parameter int YW = 296
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          busy,
  input logic          done_o,
  input logic          mem_rd_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [AW-1:0] coef_base_i,
  input logic [YW-1:0] y_o
);

  AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7

  AST_RESULT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> $stable(y_o)); // R7

  AST_FIRST_READ_COEF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy) |=> (mem_rd_o && mem_addr_o == $past(coef_base_i))); // R3

  AST_QUIET_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> !mem_rd_o); // R10

endmodule

bind sw_fir_array swfir_chk #(.AW(AW), .YW(P*ACCW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .busy        (busy),
  .done_o      (done_o),
  .mem_rd_o    (mem_rd_o),
  .mem_addr_o  (mem_addr_o),
  .coef_base_i (coef_base_i),
  .y_o         (y_o)
);

// File: tb/sw_fir_array_bench.sv
`timescale 1ns/1ps
module sw_fir_array_bench;

  localparam int P    = 8;
  localparam int W    = 16;
  localparam int NMAX = 32;
  localparam int AW   = 8;
  localparam int TW   = $clog2(NMAX+1);
  localparam int ACCW = 2*W + $clog2(NMAX);

  typedef struct {
    longint y [P];
    int     nrd;
    int     a0, a1, a2;
  } exp_t;

  logic              clk, rst_n, start;
  logic [TW-1:0]     ntaps;
  logic [AW-1:0]     cbase, dbase;
  logic              mem_rd;
  logic [AW-1:0]     mem_addr;
  logic [P*W-1:0]    mem_rdata;
  logic [P*ACCW-1:0] y;
  logic              done;

  logic [P*W-1:0] mem [256];
  exp_t exp_q [$];
  int checks, failures;
  int rd_cnt;
  int rd_addr [3];
  logic prev_done;

  sw_fir_array #(.P(P), .W(W), .NMAX(NMAX), .AW(AW)) u_sw_fir_array (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ntaps_i(ntaps),
    .coef_base_i(cbase), .data_base_i(dbase), .mem_rd_o(mem_rd),
    .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata), .y_o(y), .done_o(done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [W-1:0] elem(int a, int e);
    int v;
    if ((a >= 64 && a < 72) || (a >= 140 && a < 144)) return 16'h8000;
    v = (a*613 + e*97 + a*e*31 + 7) % 65536;
    return v[15:0];
  endfunction

  initial begin
    for (int a = 0; a < 256; a++)
      for (int e = 0; e < P; e++) mem[a][e*W +: W] = elem(a, e);
  end

  always_ff @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr];

  function automatic longint sx(int db, int m);
    int q, e;
    logic signed [W-1:0] v;
    q = (m >= 0) ? m / P : -((-m + P - 1) / P);
    e = m - q * P;
    v = elem(db + q, e);
    return longint'(v);
  endfunction

  function automatic longint cf(int cb, int i);
    logic signed [W-1:0] v;
    v = elem(cb + i / P, i % P);
    return longint'(v);
  endfunction

  task automatic chk(bit ok, string req, longint act, longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Monitor: counts reads and compares results against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rd) begin
        if (rd_cnt < 3) rd_addr[rd_cnt] = int'(mem_addr);
        rd_cnt++;
      end
      if (done) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7 unexpected done", 1, 0);
        end else begin
          exp_t ex;
          bit ok;
          ex = exp_q.pop_front();
          ok = 1'b1;
          for (int j = 0; j < P; j++) begin
            longint act;
            act = longint'($signed(y[j*ACCW +: ACCW]));
            if (act != ex.y[j]) begin
              ok = 1'b0;
              chk(1'b0, "R4/R5/R8/R9 slice value", act, ex.y[j]);
            end
          end
          if (ok) chk(1'b1, "R4", 0, 0);
          chk(rd_cnt == ex.nrd, "R6 read count", rd_cnt, ex.nrd);
          chk(rd_addr[0] == ex.a0, "R3 first address", rd_addr[0], ex.a0);
          chk(rd_addr[1] == ex.a1, "R3 second address", rd_addr[1], ex.a1);
          if (ex.nrd >= 3) chk(rd_addr[2] == ex.a2, "R3 third address", rd_addr[2], ex.a2);
        end
        rd_cnt = 0;
      end
      if (done && prev_done) chk(1'b0, "R7 done width", 2, 1);
      prev_done = done;
    end
  end

  task automatic run_case(int n, int cb, int db, bit poke);
    exp_t ex;
    for (int j = 0; j < P; j++) begin
      longint s;
      s = 0;
      for (int i = 0; i < n; i++) s += cf(cb, i) * sx(db, j - i);
      ex.y[j] = s;
    end
    ex.nrd = (n + P - 1) / P + 1 + (n - 1 + P - 1) / P;
    ex.a0 = cb;
    ex.a1 = db;
    ex.a2 = db - 1;
    exp_q.push_back(ex);
    @(negedge clk);
    ntaps = TW'(n); cbase = AW'(cb); dbase = AW'(db); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R2: a start while busy must be ignored
      repeat (3) @(negedge clk);
      ntaps = TW'(1); cbase = AW'(cb + 1); dbase = AW'(db + 1); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    repeat (3) @(negedge clk);
    for (int j = 0; j < P; j++) begin
      longint act;
      act = longint'($signed(y[j*ACCW +: ACCW]));
      if (act != ex.y[j]) chk(1'b0, "R7 hold after done", act, ex.y[j]);
    end
    chk(mem_rd == 1'b0, "R10 idle after done", longint'(mem_rd), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0; failures = 0; rd_cnt = 0; prev_done = 1'b0;
    rst_n = 1'b0; start = 1'b0; ntaps = '0; cbase = '0; dbase = '0;
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && mem_rd == 1'b0, "R1 reset outputs", longint'({done, mem_rd}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(y == '0, "R1 accumulators zero", longint'(y[ACCW-1:0]), 0);
    chk(mem_rd == 1'b0, "R1 no read after reset", longint'(mem_rd), 0);
    run_case(1, 128, 2, 1'b0);   // R9
    run_case(5, 128, 1, 1'b0);   // R4
    run_case(8, 129, 3, 1'b0);   // R5 exactly one group
    run_case(9, 130, 4, 1'b0);   // R6 coefficient refetch
    run_case(17, 131, 5, 1'b1);  // R2 start while busy
    run_case(32, 140, 68, 1'b0); // R8 full-scale
    run_case(32, 132, 10, 1'b0); // R6 NMAX taps
    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R7 all runs completed", exp_q.size(), 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule